// File: doc/BRIEF.md
# Core debug port controller

This block connects an external debug bridge to a processor core. The bridge issues read and write commands with a level strobe, a write enable, a 16-bit address and 32-bit write data. The controller decodes each address into one of three targets: the general-purpose register file, two local debug control registers, or the control and status register file. Each target is reached through a simple request/done port, and the bridge gets one acknowledge pulse when the command finishes.

The controller also holds the halt state of the core. A running core is halted by any of these:
- a software breakpoint,
- the external stall input,
- a retired instruction while single-step is enabled,
- an illegal instruction or an interrupt, when the trap-to-debugger enable for that cause is set.

When the stall input falls, the core resumes from where it stopped. Register-file and CSR accesses are serviced only while the core is halted. Commands to the local debug registers are serviced at any time.

Top module: `dbg_port_ctrl`

## Requirements
- R1: After reset, halted_o, bp_hit_o, cmd_ack_o, gpr_req_o and csr_req_o are 0, and both debug registers read as zero.
- R2: An address whose bits [15:11] equal 5'b00001 and whose bits [10:5] are zero targets GPR number addr[4:0]. An address whose bits [15:11] equal 5'b00110 targets the debug registers. Every other address goes to the CSR port. The full 16-bit address appears on tgt_addr_o while a target request is high.
- R3: The debug register at 0x3010 holds single-step enable in bit 22. The debug register at 0x3014 holds interrupt trap enable in bit 7 and illegal-instruction trap enable in bit 6. All other bits read as zero, and writes to them are ignored. Other offsets in the debug group read as zero.
- R4: A debug register command sampled at a rising edge is acknowledged after the next edge. cmd_ack_o is a one-cycle pulse, and read data is valid while it is high.
- R5: A GPR or CSR command is not issued while the core runs. It is held until halted_o is 1. The target request then stays high until its done input is seen, and the acknowledge, carrying the target's read data, follows one cycle after done.
- R6: brk_i while running sets halted_o and bp_hit_o at the next edge. bp_hit_o stays high until the core resumes.
- R7: stall_i high while running halts the core at the next edge. A falling stall_i while halted resumes the core at the next edge and clears bp_hit_o.
- R8: With single-step enabled, retire_i while running halts the core at the next edge. With it disabled, retire_i does not halt the core.
- R9: illegal_i halts the core only when bit 6 of 0x3014 is set. irq_i halts the core only when bit 7 is set.
- R10: While halted, brk_i, retire_i, illegal_i and irq_i have no effect. In particular, bp_hit_o stays 0 after a halt caused by stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low asynchronous reset |
| cmd_req_i | input | 1 | command strobe, held until acknowledged |
| cmd_we_i | input | 1 | command is a write |
| cmd_addr_i | input | 16 | command address |
| cmd_wdata_i | input | 32 | write data |
| cmd_rdata_o | output | 32 | read data, valid with acknowledge |
| cmd_ack_o | output | 1 | command completed |
| stall_i | input | 1 | halt request from the debug side |
| bp_hit_o | output | 1 | halted on a software breakpoint |
| halted_o | output | 1 | core is halted |
| brk_i | input | 1 | software breakpoint executed |
| retire_i | input | 1 | one instruction retired |
| illegal_i | input | 1 | illegal instruction detected |
| irq_i | input | 1 | interrupt taken |
| tgt_we_o | output | 1 | target access is a write |
| tgt_addr_o | output | 16 | target address |
| tgt_wdata_o | output | 32 | target write data |
| gpr_req_o | output | 1 | GPR file request |
| gpr_done_i | input | 1 | GPR file done |
| gpr_rdata_i | input | 32 | GPR read data |
| csr_req_o | output | 1 | CSR file request |
| csr_done_i | input | 1 | CSR file done |
| csr_rdata_i | input | 32 | CSR read data |

## Verification
Debug register commands are acknowledged exactly one edge after the strobe is sampled. The bench counts edges until the acknowledge and requires a count of 1. The bench's GPR and CSR stubs raise done one edge after they see a request, so a command issued while halted is due at edge 3. A command issued while running must show no request and no acknowledge until the core halts. Halt and resume results are due one edge after the causing input is sampled. The bench drives inputs on falling edges and reads outputs on the next falling edge, so each check falls between the edge that produces the result and the edge after it.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    typedef enum logic [1:0] {
        TGT_GPR  = 2'd0,
        TGT_DREG = 2'd1,
        TGT_CSR  = 2'd2
    } tgt_e;

    typedef enum logic [1:0] {
        DSEL_NONE = 2'd0,
        DSEL_STEP = 2'd1,
        DSEL_TRAP = 2'd2
    } dsel_e;

    typedef enum logic [1:0] {
        CS_IDLE  = 2'd0,
        CS_HOLD  = 2'd1,
        CS_ISSUE = 2'd2,
        CS_ACK   = 2'd3
    } cstate_e;
endpackage

// File: rtl/dbg_addr_decode.sv
module dbg_addr_decode
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int GRP_W = 5,
    parameter int IDX_W = 5,
    parameter logic [GRP_W-1:0] GPR_GRP = 5'b00001,
    parameter logic [GRP_W-1:0] DREG_GRP = 5'b00110,
    parameter logic [ADDR_W-GRP_W-1:0] STEP_OFS = 11'h010,
    parameter logic [ADDR_W-GRP_W-1:0] TRAP_OFS = 11'h014
) (
    input  logic [ADDR_W-1:0] addr_i,
    output tgt_e              tgt_o,
    output dsel_e             dsel_o
);
    localparam int OFS_W = ADDR_W - GRP_W;

    logic [GRP_W-1:0] grp;
    logic [OFS_W-1:0] ofs;

    assign grp = addr_i[ADDR_W-1 -: GRP_W];
    assign ofs = addr_i[OFS_W-1:0];

    always_comb begin
        tgt_o  = TGT_CSR;
        dsel_o = DSEL_NONE;
        if (grp == GPR_GRP && ofs[OFS_W-1:IDX_W] == '0) begin
            tgt_o = TGT_GPR;
        end else if (grp == DREG_GRP) begin
            tgt_o = TGT_DREG;
            if (ofs == STEP_OFS) dsel_o = DSEL_STEP;
            else if (ofs == TRAP_OFS) dsel_o = DSEL_TRAP;
        end
    end

    always_comb begin
        assert_tgt_valid_R2: assert (tgt_o != 2'd3);
    end
endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stall_i,
    input  logic brk_i,
    input  logic retire_i,
    input  logic illegal_i,
    input  logic irq_i,
    input  logic step_en_i,
    input  logic trap_irq_i,
    input  logic trap_ill_i,
    output logic halted_o,
    output logic bp_hit_o
);
    typedef struct packed {
        logic halted;
        logic bp;
        logic stall_prev;
    } hstate_t;

    hstate_t q, d;
    logic halt_cause;

    always_comb begin
        d = q;
        d.stall_prev = stall_i;
        halt_cause = brk_i | stall_i | (step_en_i & retire_i)
                   | (trap_ill_i & illegal_i) | (trap_irq_i & irq_i);
        if (!q.halted) begin
            if (halt_cause) d.halted = 1'b1;
            if (brk_i) d.bp = 1'b1;
        end else if (q.stall_prev && !stall_i) begin
            d.halted = 1'b0;
            d.bp     = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign halted_o = q.halted;
    assign bp_hit_o = q.bp;

    assert_brk_halts_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halted_o && brk_i) |=> (halted_o && bp_hit_o));
    assert_bp_only_halted_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bp_hit_o |-> halted_o);
    assert_stall_halts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_i |=> halted_o);
    assert_step_halts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halted_o && step_en_i && retire_i) |=> halted_o);
    assert_ill_trap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!halted_o && trap_ill_i && illegal_i) |=> halted_o);
    assert_no_new_bp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (halted_o && !bp_hit_o) |=> !bp_hit_o);
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int STEP_BIT = 22,
    parameter int IRQ_BIT = 7,
    parameter int ILL_BIT = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  tgt_e              tgt_i,
    input  dsel_e             dsel_i,
    input  logic              halted_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              tgt_we_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [DATA_W-1:0] tgt_wdata_o,
    output logic              gpr_req_o,
    input  logic              gpr_done_i,
    input  logic [DATA_W-1:0] gpr_rdata_i,
    output logic              csr_req_o,
    input  logic              csr_done_i,
    input  logic [DATA_W-1:0] csr_rdata_i,
    output logic              step_en_o,
    output logic              trap_irq_o,
    output logic              trap_ill_o
);
    typedef struct packed {
        cstate_e           st;
        tgt_e              tgt;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              step;
        logic              tirq;
        logic              till;
    } cstate_t;

    cstate_t q, d;
    logic [DATA_W-1:0] step_rd, trap_rd;
    logic              done;

    always_comb begin
        step_rd = '0;
        step_rd[STEP_BIT] = q.step;
        trap_rd = '0;
        trap_rd[IRQ_BIT] = q.tirq;
        trap_rd[ILL_BIT] = q.till;
        done = (q.tgt == TGT_GPR) ? gpr_done_i : csr_done_i;

        d = q;
        unique case (q.st)
            CS_IDLE: begin
                if (req_i) begin
                    d.we    = we_i;
                    d.addr  = addr_i;
                    d.wdata = wdata_i;
                    d.tgt   = tgt_i;
                    if (tgt_i == TGT_DREG) begin
                        d.st    = CS_ACK;
                        d.rdata = '0;
                        if (dsel_i == DSEL_STEP) begin
                            d.rdata = step_rd;
                            if (we_i) d.step = wdata_i[STEP_BIT];
                        end else if (dsel_i == DSEL_TRAP) begin
                            d.rdata = trap_rd;
                            if (we_i) begin
                                d.tirq = wdata_i[IRQ_BIT];
                                d.till = wdata_i[ILL_BIT];
                            end
                        end
                    end else begin
                        d.st = halted_i ? CS_ISSUE : CS_HOLD;
                    end
                end
            end
            CS_HOLD: begin
                if (halted_i) d.st = CS_ISSUE;
            end
            CS_ISSUE: begin
                if (done) begin
                    d.rdata = (q.tgt == TGT_GPR) ? gpr_rdata_i : csr_rdata_i;
                    d.st    = CS_ACK;
                end
            end
            default: d.st = CS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack_o       = (q.st == CS_ACK);
    assign rdata_o     = q.rdata;
    assign tgt_we_o    = q.we;
    assign tgt_addr_o  = q.addr;
    assign tgt_wdata_o = q.wdata;
    assign gpr_req_o   = (q.st == CS_ISSUE) && (q.tgt == TGT_GPR);
    assign csr_req_o   = (q.st == CS_ISSUE) && (q.tgt == TGT_CSR);
    assign step_en_o   = q.step;
    assign trap_irq_o  = q.tirq;
    assign trap_ill_o  = q.till;

    assert_ack_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);
    assert_req_only_halted_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gpr_req_o || csr_req_o) |-> halted_i);
    assert_req_held_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gpr_req_o && !gpr_done_i) |=> gpr_req_o);
    assert_single_action_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({gpr_req_o, csr_req_o, ack_o}));
    assert_done_acks_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_req_o && csr_done_i) |=> ack_o);
endmodule

// File: rtl/dbg_port_ctrl.sv
module dbg_port_ctrl
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 32,
    parameter int GRP_W = 5,
    parameter int IDX_W = 5,
    parameter int STEP_BIT = 22,
    parameter int IRQ_BIT = 7,
    parameter int ILL_BIT = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              cmd_req_i,
    input  logic              cmd_we_i,
    input  logic [ADDR_W-1:0] cmd_addr_i,
    input  logic [DATA_W-1:0] cmd_wdata_i,
    output logic [DATA_W-1:0] cmd_rdata_o,
    output logic              cmd_ack_o,
    input  logic              stall_i,
    output logic              bp_hit_o,
    output logic              halted_o,
    input  logic              brk_i,
    input  logic              retire_i,
    input  logic              illegal_i,
    input  logic              irq_i,
    output logic              tgt_we_o,
    output logic [ADDR_W-1:0] tgt_addr_o,
    output logic [DATA_W-1:0] tgt_wdata_o,
    output logic              gpr_req_o,
    input  logic              gpr_done_i,
    input  logic [DATA_W-1:0] gpr_rdata_i,
    output logic              csr_req_o,
    input  logic              csr_done_i,
    input  logic [DATA_W-1:0] csr_rdata_i
);
    tgt_e  tgt;
    dsel_e dsel;
    logic  step_en, trap_irq, trap_ill;

    dbg_addr_decode #(
        .ADDR_W(ADDR_W), .GRP_W(GRP_W), .IDX_W(IDX_W)
    ) u_decode (
        .addr_i (cmd_addr_i),
        .tgt_o  (tgt),
        .dsel_o (dsel)
    );

    dbg_cmd_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .STEP_BIT(STEP_BIT), .IRQ_BIT(IRQ_BIT), .ILL_BIT(ILL_BIT)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (cmd_req_i),
        .we_i        (cmd_we_i),
        .addr_i      (cmd_addr_i),
        .wdata_i     (cmd_wdata_i),
        .tgt_i       (tgt),
        .dsel_i      (dsel),
        .halted_i    (halted_o),
        .ack_o       (cmd_ack_o),
        .rdata_o     (cmd_rdata_o),
        .tgt_we_o    (tgt_we_o),
        .tgt_addr_o  (tgt_addr_o),
        .tgt_wdata_o (tgt_wdata_o),
        .gpr_req_o   (gpr_req_o),
        .gpr_done_i  (gpr_done_i),
        .gpr_rdata_i (gpr_rdata_i),
        .csr_req_o   (csr_req_o),
        .csr_done_i  (csr_done_i),
        .csr_rdata_i (csr_rdata_i),
        .step_en_o   (step_en),
        .trap_irq_o  (trap_irq),
        .trap_ill_o  (trap_ill)
    );

    dbg_halt_ctrl u_halt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stall_i    (stall_i),
        .brk_i      (brk_i),
        .retire_i   (retire_i),
        .illegal_i  (illegal_i),
        .irq_i      (irq_i),
        .step_en_i  (step_en),
        .trap_irq_i (trap_irq),
        .trap_ill_i (trap_ill),
        .halted_o   (halted_o),
        .bp_hit_o   (bp_hit_o)
    );
endmodule

// File: tb/dbg_port_ctrl_tb.sv
module dbg_port_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 0, we = 0, stall = 0, brk = 0, retire = 0, ill = 0, irq = 0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack, bp, halted, twe, greq, creq;
    logic [15:0] taddr;
    logic [31:0] twdata;
    logic        gdone = 0, cdone = 0;
    logic [31:0] grdata = '0, crdata = '0;
    logic [31:0] gmem [32];
    logic [15:0] csr_last = '0;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    dbg_port_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_req_i(req), .cmd_we_i(we),
        .cmd_addr_i(addr), .cmd_wdata_i(wdata), .cmd_rdata_o(rdata),
        .cmd_ack_o(ack), .stall_i(stall), .bp_hit_o(bp), .halted_o(halted),
        .brk_i(brk), .retire_i(retire), .illegal_i(ill), .irq_i(irq),
        .tgt_we_o(twe), .tgt_addr_o(taddr), .tgt_wdata_o(twdata),
        .gpr_req_o(greq), .gpr_done_i(gdone), .gpr_rdata_i(grdata),
        .csr_req_o(creq), .csr_done_i(cdone), .csr_rdata_i(crdata)
    );

    // target stubs: done one edge after request seen
    always_ff @(posedge clk) begin
        gdone <= greq && !gdone;
        cdone <= creq && !cdone;
        if (greq && !gdone) begin
            if (twe) gmem[taddr[4:0]] <= twdata;
            grdata <= gmem[taddr[4:0]];
        end
        if (creq && !cdone) begin
            crdata   <= {16'hA5A5, taddr};
            csr_last <= taddr;
        end
    end

    // {we, addr, wdata, expected read data}
    localparam logic [80:0] VEC [12] = '{
        {1'b1, 16'h3010, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 16'h3010, 32'h0, 32'h0040_0000},
        {1'b1, 16'h3014, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 16'h3014, 32'h0, 32'h0000_00C0},
        {1'b0, 16'h3000, 32'h0, 32'h0},
        {1'b0, 16'h3018, 32'h0, 32'h0},
        {1'b1, 16'h3010, 32'hFFBF_FFFF, 32'h0},
        {1'b0, 16'h3010, 32'h0, 32'h0},
        {1'b1, 16'h3014, 32'h0000_0040, 32'h0},
        {1'b0, 16'h3014, 32'h0, 32'h0000_0040},
        {1'b1, 16'h3014, 32'hFFFF_FF3F, 32'h0},
        {1'b0, 16'h3014, 32'h0, 32'h0}
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic do_cmd(input logic w, input logic [15:0] a, input logic [31:0] dt,
                          output logic [31:0] rd, output int lat);
        @(negedge clk);
        req = 1; we = w; addr = a; wdata = dt;
        lat = -1;
        rd = '0;
        for (int i = 1; i <= 60; i++) begin
            @(posedge clk); #1;
            if (ack) begin
                lat = i;
                rd = rdata;
                break;
            end
        end
        req = 0;
        @(negedge clk);
    endtask

    task automatic resume();
        @(negedge clk) stall = 1;
        @(negedge clk) stall = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R5 watchdog expired: actual 1 expected 0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int lat;
        for (int i = 0; i < 32; i++) gmem[i] = 32'h100 + i;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!halted && !bp && !ack && !greq && !creq, "R1", "reset outputs",
            {27'd0, halted, bp, ack, greq, creq}, 32'h0);
        do_cmd(0, 16'h3010, 0, rd, lat);
        chk(rd == 0, "R1", "step reg reset", rd, 0);
        do_cmd(0, 16'h3014, 0, rd, lat);
        chk(rd == 0, "R1", "trap reg reset", rd, 0);

        // R3 R4 vector table
        for (int v = 0; v < 12; v++) begin
            do_cmd(VEC[v][80], VEC[v][79:64], VEC[v][63:32], rd, lat);
            chk(lat == 1, "R4", "debug latency", lat, 1);
            if (!VEC[v][80]) chk(rd == VEC[v][31:0], "R3", "debug readback", rd, VEC[v][31:0]);
        end
        @(negedge clk);
        chk(!ack, "R4", "ack single pulse", ack, 0);

        // R5 GPR write held while running
        fork
            do_cmd(1, 16'h0805, 32'h1234_5678, rd, lat);
            begin
                repeat (6) begin
                    @(negedge clk);
                    chk(!greq && !ack, "R5", "held while running", {greq, ack}, 0);
                end
                stall = 1;
                @(negedge clk);
                chk(halted, "R7", "stall halts", halted, 1);
            end
        join
        chk(lat > 0, "R5", "held write completes", lat, 1);
        do_cmd(0, 16'h0805, 0, rd, lat);
        chk(rd == 32'h1234_5678, "R5", "gpr readback", rd, 32'h1234_5678);
        chk(lat == 3, "R5", "gpr latency", lat, 3);
        do_cmd(0, 16'h0800, 0, rd, lat);
        chk(rd == 32'h100, "R2", "gpr0 index", rd, 32'h100);
        // R2 CSR routing
        do_cmd(0, 16'h0820, 0, rd, lat);
        chk(rd == 32'hA5A5_0820 && csr_last == 16'h0820, "R2", "0x0820 goes to csr", rd, 32'hA5A5_0820);
        do_cmd(0, 16'h07A0, 0, rd, lat);
        chk(rd == 32'hA5A5_07A0, "R2", "0x07A0 goes to csr", rd, 32'hA5A5_07A0);
        chk(lat == 3, "R5", "csr latency", lat, 3);

        // R10 events ignored while halted
        @(negedge clk) brk = 1; retire = 1; ill = 1; irq = 1;
        @(negedge clk) brk = 0; retire = 0; ill = 0; irq = 0;
        chk(!bp && halted, "R10", "brk while halted", bp, 0);
        stall = 0;
        @(negedge clk);
        chk(!halted, "R7", "stall fall resumes", halted, 0);

        // R6 breakpoint
        @(negedge clk) brk = 1;
        @(negedge clk) brk = 0;
        chk(halted && bp, "R6", "brk halts", {halted, bp}, 3);
        @(negedge clk);
        chk(bp, "R6", "bp holds", bp, 1);
        resume();
        chk(!halted && !bp, "R7", "resume clears bp", {halted, bp}, 0);

        // R8 single-step
        do_cmd(1, 16'h3010, 32'h0040_0000, rd, lat);
        @(negedge clk);
        chk(!halted, "R8", "no halt without retire", halted, 0);
        @(negedge clk) retire = 1;
        @(negedge clk) retire = 0;
        chk(halted, "R8", "step halts", halted, 1);
        resume();
        @(negedge clk) retire = 1;
        @(negedge clk) retire = 0;
        chk(halted, "R8", "step re-halts after resume", halted, 1);
        resume();
        do_cmd(1, 16'h3010, 0, rd, lat);
        @(negedge clk) retire = 1;
        @(negedge clk) retire = 0;
        chk(!halted, "R8", "step disabled", halted, 0);

        // R9 trap enables
        do_cmd(1, 16'h3014, 0, rd, lat);
        @(negedge clk) ill = 1; irq = 1;
        @(negedge clk) ill = 0; irq = 0;
        chk(!halted, "R9", "traps disabled", halted, 0);
        do_cmd(1, 16'h3014, 32'h40, rd, lat);
        @(negedge clk) irq = 1;
        @(negedge clk) irq = 0;
        chk(!halted, "R9", "irq not trapped with bit6", halted, 0);
        @(negedge clk) ill = 1;
        @(negedge clk) ill = 0;
        chk(halted, "R9", "illegal trapped", halted, 1);
        resume();
        do_cmd(1, 16'h3014, 32'h80, rd, lat);
        @(negedge clk) ill = 1;
        @(negedge clk) ill = 0;
        chk(!halted, "R9", "illegal not trapped with bit7", halted, 0);
        @(negedge clk) irq = 1;
        @(negedge clk) irq = 0;
        chk(halted, "R9", "irq trapped", halted, 1);
        chk(!bp, "R6", "no bp on irq halt", bp, 0);
        resume();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule